// File: doc/BRIEF.md
# Trigger-Latency Pixel Event Buffer

This block holds the binary hit pattern of a pixel readout matrix while the experiment decides whether the pattern is worth keeping. On every clock the whole matrix arrives as one hit bitmap, with one bit per cell and no amplitude. The bitmap is held for a programmable number of cycles. When a first-level trigger is present, the bitmap from exactly that many cycles earlier is copied into one of a few event slots. A cycle without a trigger lets its delayed bitmap drop.

Stored events wait for a second-level decision. The decisions apply in arrival order to the oldest event that has not yet been decided. A "keep" decision streams the event out one matrix row per clock on a column-wide word bus. A "discard" decision frees the slot silently. Decisions that arrive while a readout is running wait in a short queue. A trigger that finds every slot occupied is lost and counted. A decision that has no event to act on raises an error pulse.

Top module: `pixel_event_buffer`

## Requirements
- R1: A synchronous active-high reset empties every event slot, the decision queue and the latency storage. After reset `word_valid_o`, `busy_o` and `err_o` are 0 and `ovf_cnt_o` is 0. A trigger whose delayed bitmap predates the reset captures all zeros.
- R2: A trigger sampled at clock edge n captures the bitmap sampled at edge n−L, where L = `lat_i`. L is legal from 1 to LAT_DEPTH.
- R3: A delayed bitmap that meets no trigger is never stored and never appears on the output.
- R4: Up to NBUF events are stored, and they are released in strict capture order.
- R5: A kept event is emitted as ROWS consecutive words, row 0 first. Word bit c is column c of the row, which is `hits_i[r*COLS+c]`. `sof_o` is set on the row-0 word only and `eof_o` on the last-row word only.
- R6: A discard decision (`l2_strobe_i`=1, `l2_keep_i`=0) frees the oldest undecided event and produces no output word.
- R7: `busy_o` is 1 while all NBUF slots are occupied. A trigger in such a cycle is dropped and adds 1 to `ovf_cnt_o`, which saturates at its all-ones value.
- R8: A decision that arrives when no stored event lacks a decision is ignored. It drives `err_o` high for exactly the one cycle after its edge. An event captured in the same cycle does not count as stored for this decision.
- R9: Decisions arriving during a readout are queued, up to NBUF of them, and each is applied later in arrival order.
- R10: A keep decision sampled at edge n, with the sequencer idle and no older decisions pending, puts row 0 on the bus after edge n+1. After an event's last word there is one idle cycle before the next queued decision is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hits_i | input | ROWS*COLS | Hit bitmap, bit r*COLS+c is row r column c |
| lat_i | input | clog2(LAT_DEPTH+1) | Trigger latency in cycles, 1..LAT_DEPTH |
| l1_trig_i | input | 1 | First-level trigger |
| l2_strobe_i | input | 1 | Second-level decision present |
| l2_keep_i | input | 1 | 1 = read event out, 0 = discard |
| word_o | output | COLS | Readout word, one matrix row |
| word_valid_o | output | 1 | Readout word valid |
| sof_o | output | 1 | First word of an event |
| eof_o | output | 1 | Last word of an event |
| busy_o | output | 1 | All event slots occupied |
| err_o | output | 1 | Decision with nothing to decide, one-cycle pulse |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped triggers |

## Verification
The bench runs short and full-depth latencies and checks which bitmap lands in the slot. A read pointer that is off by one would capture a neighbouring cycle's pattern. It fills all four slots and keeps triggering until the drop counter wraps or sticks, which shows a missing saturation or a capture into an occupied slot. It mixes discard and keep decisions back to back during a readout, so a queue that loses, reorders or misapplies decisions shows up as wrong or missing rows in the scoreboard. It also sends decisions with nothing to decide and triggers right after reset, where stale latency contents or an error flag that does not pulse would be visible.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_READ = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pxb_delay_line.sv
module pxb_delay_line #(
    parameter int NPIX  = 8192,
    parameter int DEPTH = 512,
    parameter int LAT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPIX-1:0]  hits_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic [NPIX-1:0]  dly_o
);
    localparam int AW = $clog2(DEPTH);

    logic [NPIX-1:0] mem_q [DEPTH];
    logic [AW-1:0]   wptr_d, wptr_q;
    logic [AW-1:0]   rd_addr;

    // entry at wptr - L was written L edges ago; L == DEPTH reads the
    // slot that is overwritten at this same edge, still holding old data
    always_comb begin
        wptr_d  = wptr_q + 1'b1;
        rd_addr = wptr_q - lat_i[AW-1:0];
    end

    assign dly_o = mem_q[rd_addr];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            wptr_q         <= wptr_d;
            mem_q[wptr_q]  <= hits_i;
        end
    end

    a_r2_lat_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (lat_i != '0) && (lat_i <= LAT_W'(DEPTH)));
endmodule

// File: rtl/pxb_event_store.sv
module pxb_event_store #(
    parameter int ROWS = 256,
    parameter int COLS = 32,
    parameter int NBUF = 4,
    parameter int RW   = $clog2(ROWS),
    parameter int CW   = $clog2(NBUF + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 cap_i,
    input  logic [ROWS*COLS-1:0] cap_data_i,
    input  logic                 rel_i,
    input  logic [RW-1:0]        rd_row_i,
    output logic [CW-1:0]        count_o,
    output logic [COLS-1:0]      word_o
);
    localparam int IW = $clog2(NBUF);

    typedef struct packed {
        logic [IW-1:0] wr;
        logic [IW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ROWS*COLS-1:0] slot_q [NBUF];

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(NBUF - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        if (cap_i) ctl_d.wr = nxt(ctl_q.wr);
        if (rel_i) ctl_d.rd = nxt(ctl_q.rd);
        case ({cap_i, rel_i})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
            for (int i = 0; i < NBUF; i++) slot_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (cap_i) slot_q[ctl_q.wr] <= cap_data_i;
        end
    end

    assign count_o = ctl_q.cnt;
    assign word_o  = slot_q[ctl_q.rd][int'(rd_row_i)*COLS +: COLS];

    a_r4_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_q.cnt <= CW'(NBUF));
    a_r4_no_cap_full: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_i |-> ctl_q.cnt < CW'(NBUF));
    a_r6_rel_nonempty: assert property (@(posedge clk_i) disable iff (rst_i)
        rel_i |-> ctl_q.cnt != '0);
endmodule

// File: rtl/pxb_decision_queue.sv
module pxb_decision_queue #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          push_i,
    input  logic          keep_i,
    input  logic          pop_i,
    output logic          head_keep_o,
    output logic [CW-1:0] count_o
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] keep;
        logic [IW-1:0]    wr;
        logic [IW-1:0]    rd;
        logic [CW-1:0]    cnt;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push_i) begin
            q_d.keep[q_q.wr] = keep_i;
            q_d.wr           = nxt(q_q.wr);
        end
        if (pop_i) q_d.rd = nxt(q_q.rd);
        case ({push_i, pop_i})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q_q <= '0;
        else       q_q <= q_d;
    end

    assign head_keep_o = q_q.keep[q_q.rd];
    assign count_o     = q_q.cnt;

    a_r9_queue_room: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && !pop_i) |-> q_q.cnt < CW'(DEPTH));
    a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i |-> q_q.cnt != '0);
endmodule

// File: rtl/pixel_event_buffer.sv
module pixel_event_buffer
    import pxb_pkg::*;
#(
    parameter int ROWS      = 256,
    parameter int COLS      = 32,
    parameter int NBUF      = 4,
    parameter int LAT_DEPTH = 512,
    parameter int OVF_W     = 8,
    parameter int NPIX      = ROWS * COLS,
    parameter int LAT_W     = $clog2(LAT_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPIX-1:0]  hits_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic             l1_trig_i,
    input  logic             l2_strobe_i,
    input  logic             l2_keep_i,
    output logic [COLS-1:0]  word_o,
    output logic             word_valid_o,
    output logic             sof_o,
    output logic             eof_o,
    output logic             busy_o,
    output logic             err_o,
    output logic [OVF_W-1:0] ovf_cnt_o
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(NBUF + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [RW-1:0]    row;
        logic [OVF_W-1:0] ovf;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    logic [NPIX-1:0] dly;
    logic [CW-1:0]   st_cnt, q_cnt;
    logic            q_head_keep;
    logic            cap, rel, q_push, q_pop;
    int              undecided;

    pxb_delay_line #(.NPIX(NPIX), .DEPTH(LAT_DEPTH), .LAT_W(LAT_W)) u_dly (
        .clk_i (clk_i), .rst_i (rst_i), .hits_i(hits_i),
        .lat_i (lat_i), .dly_o (dly)
    );

    pxb_event_store #(.ROWS(ROWS), .COLS(COLS), .NBUF(NBUF), .RW(RW), .CW(CW)) u_store (
        .clk_i     (clk_i), .rst_i (rst_i), .cap_i(cap), .cap_data_i(dly),
        .rel_i     (rel), .rd_row_i(s_q.row), .count_o(st_cnt), .word_o(word_o)
    );

    pxb_decision_queue #(.DEPTH(NBUF), .CW(CW)) u_queue (
        .clk_i      (clk_i), .rst_i(rst_i), .push_i(q_push), .keep_i(l2_keep_i),
        .pop_i      (q_pop), .head_keep_o(q_head_keep), .count_o(q_cnt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        cap       = 1'b0;
        rel       = 1'b0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        // events stored that have no decision yet (queued or in readout)
        undecided = int'(st_cnt) - int'(q_cnt) - ((s_q.state == SEQ_READ) ? 1 : 0);

        if (l1_trig_i) begin
            if (st_cnt == CW'(NBUF)) begin
                if (s_q.ovf != '1) s_d.ovf = s_q.ovf + 1'b1;
            end else begin
                cap = 1'b1;
            end
        end

        if (l2_strobe_i) begin
            if (undecided > 0) q_push = 1'b1;
            else               s_d.err = 1'b1;
        end

        case (s_q.state)
            SEQ_IDLE: begin
                if (q_cnt != '0) begin
                    q_pop = 1'b1;
                    if (q_head_keep) begin
                        s_d.state = SEQ_READ;
                        s_d.row   = '0;
                    end else begin
                        rel = 1'b1;
                    end
                end
            end
            SEQ_READ: begin
                if (s_q.row == RW'(ROWS - 1)) begin
                    rel       = 1'b1;
                    s_d.state = SEQ_IDLE;
                end else begin
                    s_d.row = s_q.row + 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.state <= SEQ_IDLE;
            s_q.row   <= '0;
            s_q.ovf   <= '0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_valid_o = (s_q.state == SEQ_READ);
    assign sof_o        = word_valid_o && (s_q.row == '0);
    assign eof_o        = word_valid_o && (s_q.row == RW'(ROWS - 1));
    assign busy_o       = (st_cnt == CW'(NBUF));
    assign err_o        = s_q.err;
    assign ovf_cnt_o    = s_q.ovf;

    a_r7_drop_counts: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && l1_trig_i && ovf_cnt_o != '1) |=> ovf_cnt_o == $past(ovf_cnt_o) + 1'b1);
    a_r7_saturates: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_cnt_o == '1) |=> ovf_cnt_o == '1);
    a_r8_err_when_empty: assert property (@(posedge clk_i) disable iff (rst_i)
        (l2_strobe_i && st_cnt == '0) |=> err_o);
    a_r5_frame_contig: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_valid_o && !eof_o) |=> (word_valid_o && !sof_o));
    a_r5_frame_starts: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(word_valid_o) |-> sof_o);
endmodule

// File: tb/pixel_event_buffer_test.sv
`timescale 1ns/1ps
module pixel_event_buffer_test;
    localparam int ROWS = 4, COLS = 32, NBUF = 4, LAT_DEPTH = 16, OVF_W = 2;
    localparam int NPIX  = ROWS * COLS;
    localparam int LAT_W = $clog2(LAT_DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic [NPIX-1:0]  hits = '0;
    logic [LAT_W-1:0] lat_in = LAT_W'(1);
    logic l1 = 1'b0, l2s = 1'b0, l2k = 1'b0;
    logic [COLS-1:0]  word;
    logic word_valid, sof, eof, busy, err;
    logic [OVF_W-1:0] ovf;

    int checks = 0, errors = 0;
    int edge_n = 0, lat = 1, ovf_exp = 0;
    logic [NPIX-1:0] hist [64];
    logic [NPIX-1:0] mq [$];
    logic [COLS+1:0] expq [$];

    always #4 clk = ~clk;

    pixel_event_buffer #(.ROWS(ROWS), .COLS(COLS), .NBUF(NBUF),
                         .LAT_DEPTH(LAT_DEPTH), .OVF_W(OVF_W)) uut (
        .clk_i(clk), .rst_i(rst), .hits_i(hits), .lat_i(lat_in),
        .l1_trig_i(l1), .l2_strobe_i(l2s), .l2_keep_i(l2k),
        .word_o(word), .word_valid_o(word_valid), .sof_o(sof), .eof_o(eof),
        .busy_o(busy), .err_o(err), .ovf_cnt_o(ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NPIX-1:0] patt(input int n);
        logic [NPIX-1:0] v;
        for (int r = 0; r < ROWS; r++)
            v[r*COLS +: COLS] = {8'(r + 1), 8'(n), 16'(n * 13 + r)};
        return v;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5", "unexpected word", 64'(word), 64'h0);
            end else begin
                logic [COLS+1:0] e;
                e = expq.pop_front();
                check({sof, eof, word} == e, "R5", "row word/sof/eof",
                      64'({sof, eof, word}), 64'(e));
            end
        end
    end

    task automatic step(input bit trig, input bit strb, input bit keep);
        logic [NPIX-1:0] h, dl, ev;
        bit full, exp_err;
        h = patt(edge_n);
        hits = h; l1 = trig; l2s = strb; l2k = keep;
        lat_in = LAT_W'(lat);
        hist[edge_n % 64] = h;
        dl = (edge_n >= lat) ? hist[(edge_n - lat) % 64] : '0;
        full = (mq.size() >= NBUF);
        exp_err = 1'b0;
        if (strb) begin
            if (mq.size() == 0) exp_err = 1'b1;
            else begin
                ev = mq.pop_front();
                if (keep)
                    for (int r = 0; r < ROWS; r++)
                        expq.push_back({r == 0, r == ROWS - 1, ev[r*COLS +: COLS]});
            end
        end
        if (trig) begin
            if (full) begin if (ovf_exp < (1 << OVF_W) - 1) ovf_exp++; end
            else mq.push_back(dl);
        end
        @(posedge clk);
        edge_n++;
        #1;
        if (strb) check(err == exp_err, "R8", "error pulse", 64'(err), 64'(exp_err));
        @(negedge clk);
        l1 = 1'b0; l2s = 1'b0; l2k = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1; l1 = 1'b0; l2s = 1'b0; l2k = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        edge_n = 0; ovf_exp = 0;
        mq.delete();
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        lat = 5;
        do_reset();
        // R1: reset state
        check(word_valid == 1'b0, "R1", "valid after reset", 64'(word_valid), 0);
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 0);
        check(err == 1'b0, "R1", "err after reset", 64'(err), 0);
        check(ovf == '0, "R1", "ovf after reset", 64'(ovf), 0);

        // R2 latency 5, R10 start timing
        idle(10);
        step(1'b1, 1'b0, 1'b0);
        idle(3);
        step(1'b0, 1'b1, 1'b1);
        check(word_valid == 1'b0, "R10", "no word one cycle after decision", 64'(word_valid), 0);
        step(1'b0, 1'b0, 1'b0);
        check(word_valid && sof, "R10", "row 0 two edges after decision",
              64'({word_valid, sof}), 64'h3);
        idle(12);

        // R2 extremes L=1 and L=LAT_DEPTH; R9 second decision queued in readout
        lat = 1;
        step(1'b1, 1'b0, 1'b0);
        lat = LAT_DEPTH;
        idle(2);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        idle(2);
        step(1'b0, 1'b1, 1'b1);
        idle(16);
        check(expq.size() == 0, "R9", "queued keep delivered", 64'(expq.size()), 0);

        // R8 decision with nothing stored, then pulse ends
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check(err == 1'b0, "R8", "err is a single-cycle pulse", 64'(err), 0);
        // R8 more decisions than events; R3 unstrobed cycles are not stored
        lat = 3;
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        idle(6);
        check(word_valid == 1'b0, "R3", "no output for dropped bitmaps", 64'(word_valid), 0);

        // R6, R4 ordering: discard, keep, discard back to back
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        idle(16);
        check(busy == 1'b0, "R6", "slots freed", 64'(busy), 0);
        check(expq.size() == 0, "R6", "only kept event emitted", 64'(expq.size()), 0);

        // R7 fill, drop, saturate
        for (int i = 0; i < NBUF; i++) step(1'b1, 1'b0, 1'b0);
        check(busy == 1'b1, "R7", "busy when full", 64'(busy), 1);
        step(1'b1, 1'b0, 1'b0);
        check(ovf == OVF_W'(ovf_exp), "R7", "one drop counted", 64'(ovf), 64'(ovf_exp));
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        check(ovf == '1, "R7", "counter saturates", 64'(ovf), 64'(ovf_exp));
        // R9 four decisions during one readout, R4 order
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        idle(30);
        check(busy == 1'b0, "R4", "all slots released", 64'(busy), 0);
        check(expq.size() == 0, "R9", "all queued decisions applied", 64'(expq.size()), 0);

        // R1 latency storage cleared by reset
        lat = 6;
        idle(8);
        do_reset();
        check(ovf == '0, "R1", "ovf cleared", 64'(ovf), 0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        idle(10);
        check(expq.size() == 0, "R1", "zero event delivered", 64'(expq.size()), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule